// File: doc/BRIEF.md
# Unidirectional Torus Tile Router

This block is the router that sits in one tile of a 10-column by 12-row network-on-chip whose edges wrap around, forming a torus. One instance serves one of two networks, chosen by a parameter. The forward network moves flits only eastward and southward. The reverse network moves them only westward and northward. A flit can therefore reach any tile by travelling forward in X until its column matches, and then forward in Y until its row matches. At that point it is handed to the tile.

Each flit is 264 bits wide. Bits [263:260] hold the destination column, bits [259:256] hold the destination row, and bits [255:0] hold a 256-bit payload. The router has three inbound streams: the Y-direction link, the X-direction link and local injection. It has three outbound streams: the X link, the Y link and local ejection.

Every stream uses valid/ready. A transfer happens on a rising edge where both valid and ready are high. A sender keeps its flit and valid stable until that edge. A receiver may hold ready low for as long as it likes. An output keeps its flit until it is taken. Each output has a single register, so a stalled output back-pressures only the inputs routed to it. The tile's coordinates, the network and whether the tile may take local traffic are all parameters.

Top module: `torus_router`

## Requirements
- R1: A flit whose destination column (bits [263:260]) differs from the tile's column leaves on the X output. It appears with its content unchanged in the cycle after it is accepted. This also holds when the next hop wraps from the last column to column 0.
- R2: A flit whose destination column matches but whose destination row (bits [259:256]) differs leaves on the Y output, one cycle after it is accepted.
- R3: On an enabled tile, a flit whose destination matches both coordinates leaves on the eject output, one cycle after it is accepted.
- R4: When inputs compete for one output, the Y input wins over the X input, and the X input wins over local injection. A losing input sees ready low and keeps its flit. An input is also refused while its target output holds an untaken flit that is not being drained in that cycle.
- R5: While an output is valid and its ready is low, the output stays valid and its flit does not change.
- R6: A flit with a destination column of 10 or more, or a destination row of 12 or more, is accepted at once and appears on no output. `dest_err` is high for exactly the next cycle.
- R7: On a tile built with local traffic disabled, inject ready stays low and eject valid stays low. A flit addressed to that tile is dropped with `dest_err`, as in R6. Transit flits are still forwarded.
- R8: An output that stays ready accepts one flit on every cycle, so a back-to-back burst passes with no gaps.
- R9: During reset all output valids and `dest_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| yin_valid | input | 1 | Y-direction inbound flit valid |
| yin_ready | output | 1 | Y-direction inbound flit accepted |
| yin_flit | input | 264 | Y-direction inbound flit |
| xin_valid | input | 1 | X-direction inbound flit valid |
| xin_ready | output | 1 | X-direction inbound flit accepted |
| xin_flit | input | 264 | X-direction inbound flit |
| inj_valid | input | 1 | Local injection valid |
| inj_ready | output | 1 | Local injection accepted |
| inj_flit | input | 264 | Local injection flit |
| xout_valid | output | 1 | X-direction outbound flit valid |
| xout_ready | input | 1 | Downstream X neighbour can take the flit |
| xout_flit | output | 264 | X-direction outbound flit |
| yout_valid | output | 1 | Y-direction outbound flit valid |
| yout_ready | input | 1 | Downstream Y neighbour can take the flit |
| yout_flit | output | 264 | Y-direction outbound flit |
| ej_valid | output | 1 | Local eject valid |
| ej_ready | input | 1 | Tile can take the ejected flit |
| ej_flit | output | 264 | Local eject flit |
| dest_err | output | 1 | One-cycle pulse after a flit was dropped |

## Verification
The checks on the output side depend on two properties of the inputs. Every sender keeps valid and flit stable until the handshake. Every flit arriving on the Y input already lies in the tile's column, or else carries an out-of-range coordinate. The stimulus follows both rules. It only changes an input after the edge at which that input was seen accepted, and it draws Y-input destinations from the tile's own column, apart from occasional out-of-range values. Downstream ready signals are toggled freely, because the block places no rule on them.

// File: rtl/tr_pkg.sv
package tr_pkg;

  localparam int NPORT = 3;

  // input indices, lower index = higher priority
  localparam int IN_Y = 0;
  localparam int IN_X = 1;
  localparam int IN_L = 2;

  // output indices
  localparam int OUT_X = 0;
  localparam int OUT_Y = 1;
  localparam int OUT_E = 2;

  typedef enum logic {
    NET_FWD = 1'b0,   // east and south
    NET_REV = 1'b1    // west and north
  } net_dir_e;

  // forward hops left on a ring of 'size' tiles in the network's direction
  function automatic int unsigned ring_hops(int unsigned dst, int unsigned here,
                                            int unsigned size, net_dir_e dir);
    if (dir == NET_FWD) return (dst + size - here) % size;
    else                return (here + size - dst) % size;
  endfunction

endpackage

// File: rtl/tr_route.sv
module tr_route
  import tr_pkg::*;
#(
  parameter int unsigned GRID_W    = 10,
  parameter int unsigned GRID_H    = 12,
  parameter int unsigned CRD_W     = 4,
  parameter int unsigned PAYLOAD_W = 256,
  parameter int unsigned MY_X      = 0,
  parameter int unsigned MY_Y      = 0,
  parameter net_dir_e    DIR       = NET_FWD,
  parameter bit          LOCAL_EN  = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [2*CRD_W+PAYLOAD_W-1:0]    in_flit,
  output logic [NPORT-1:0]                req,
  output logic                            drop
);

  localparam int unsigned FLIT_W = 2*CRD_W + PAYLOAD_W;

  logic [CRD_W-1:0] dst_x, dst_y;
  int unsigned      dxu, dyu, hx, hy;
  logic             bad, home;

  assign dst_x = in_flit[FLIT_W-1 -: CRD_W];
  assign dst_y = in_flit[FLIT_W-CRD_W-1 -: CRD_W];
  assign dxu   = 32'(dst_x);
  assign dyu   = 32'(dst_y);

  assign bad  = (dxu >= GRID_W) || (dyu >= GRID_H);
  assign hx   = ring_hops(dxu, MY_X, GRID_W, DIR);
  assign hy   = ring_hops(dyu, MY_Y, GRID_H, DIR);
  assign home = (hx == 0) && (hy == 0);

  always_comb begin
    req  = '0;
    drop = 1'b0;
    if (in_valid) begin
      if (bad || (home && !LOCAL_EN)) drop = 1'b1;
      else if (hx != 0)               req[OUT_X] = 1'b1;
      else if (hy != 0)               req[OUT_Y] = 1'b1;
      else                            req[OUT_E] = 1'b1;
    end
  end

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot({req, drop})) else $error("route decision not unique"); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ({req, drop} == '0)) else $error("idle input requests"); // R4

endmodule

// File: rtl/tr_arb.sv
module tr_arb
  import tr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] want,
  input  logic             slot_free,
  output logic [NPORT-1:0] gnt
);

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (want[i] && slot_free && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)) else $error("multiple grants"); // R4
  AST_GRANT_WANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~want) == '0) else $error("grant without request"); // R4
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (want[0] && slot_free) |-> gnt[0]) else $error("through traffic lost priority"); // R4

endmodule

// File: rtl/tr_outreg.sv
module tr_outreg #(
  parameter int unsigned W = 264
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_flit,
  output logic         free,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_flit
);

  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_flit  <= load_flit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)))
    else $error("stalled output changed"); // R5
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready)) else $error("output overwritten"); // R5

endmodule

// File: rtl/torus_router.sv
module torus_router
  import tr_pkg::*;
#(
  parameter int unsigned GRID_W    = 10,
  parameter int unsigned GRID_H    = 12,
  parameter int unsigned CRD_W     = 4,
  parameter int unsigned PAYLOAD_W = 256,
  parameter int unsigned MY_X      = 0,
  parameter int unsigned MY_Y      = 0,
  parameter int unsigned NET_SEL   = 0,
  parameter bit          LOCAL_EN  = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         yin_valid,
  output logic                         yin_ready,
  input  logic [2*CRD_W+PAYLOAD_W-1:0] yin_flit,
  input  logic                         xin_valid,
  output logic                         xin_ready,
  input  logic [2*CRD_W+PAYLOAD_W-1:0] xin_flit,
  input  logic                         inj_valid,
  output logic                         inj_ready,
  input  logic [2*CRD_W+PAYLOAD_W-1:0] inj_flit,
  output logic                         xout_valid,
  input  logic                         xout_ready,
  output logic [2*CRD_W+PAYLOAD_W-1:0] xout_flit,
  output logic                         yout_valid,
  input  logic                         yout_ready,
  output logic [2*CRD_W+PAYLOAD_W-1:0] yout_flit,
  output logic                         ej_valid,
  input  logic                         ej_ready,
  output logic [2*CRD_W+PAYLOAD_W-1:0] ej_flit,
  output logic                         dest_err
);

  localparam int unsigned FLIT_W = 2*CRD_W + PAYLOAD_W;
  localparam net_dir_e    DIR    = (NET_SEL == 0) ? NET_FWD : NET_REV;
  localparam logic [CRD_W-1:0] HX = CRD_W'(MY_X);
  localparam logic [CRD_W-1:0] HY = CRD_W'(MY_Y);

  logic              in_v   [NPORT];
  logic [FLIT_W-1:0] in_fl  [NPORT];
  logic              in_rdy [NPORT];
  logic [NPORT-1:0]  req    [NPORT];
  logic              drop_v [NPORT];

  logic [NPORT-1:0]  want   [NPORT];
  logic [NPORT-1:0]  gnt    [NPORT];
  logic              slot_free [NPORT];
  logic              load   [NPORT];
  logic [FLIT_W-1:0] load_fl[NPORT];
  logic              o_v    [NPORT];
  logic              o_rdy  [NPORT];
  logic [FLIT_W-1:0] o_fl   [NPORT];
  logic              err_q;

  // inbound side
  assign in_v[IN_Y]  = yin_valid;
  assign in_v[IN_X]  = xin_valid;
  assign in_v[IN_L]  = inj_valid & LOCAL_EN;
  assign in_fl[IN_Y] = yin_flit;
  assign in_fl[IN_X] = xin_flit;
  assign in_fl[IN_L] = inj_flit;

  generate
    for (genvar i = 0; i < NPORT; i++) begin : g_in
      tr_route #(
        .GRID_W(GRID_W), .GRID_H(GRID_H), .CRD_W(CRD_W), .PAYLOAD_W(PAYLOAD_W),
        .MY_X(MY_X), .MY_Y(MY_Y), .DIR(DIR), .LOCAL_EN(LOCAL_EN)
      ) u_route (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_v[i]), .in_flit(in_fl[i]),
        .req(req[i]), .drop(drop_v[i])
      );
    end
  endgenerate

  // transpose requests into per-output want vectors
  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        want[o][i] = req[i][o];
  end

  // outbound side
  assign o_rdy[OUT_X] = xout_ready;
  assign o_rdy[OUT_Y] = yout_ready;
  assign o_rdy[OUT_E] = ej_ready;

  generate
    for (genvar o = 0; o < NPORT; o++) begin : g_out
      tr_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .want(want[o]), .slot_free(slot_free[o]), .gnt(gnt[o])
      );

      always_comb begin
        load_fl[o] = '0;
        for (int i = 0; i < NPORT; i++)
          if (gnt[o][i]) load_fl[o] = in_fl[i];
      end
      assign load[o] = |gnt[o];

      tr_outreg #(.W(FLIT_W)) u_oreg (
        .clk(clk), .rst_n(rst_n),
        .load(load[o]), .load_flit(load_fl[o]), .free(slot_free[o]),
        .out_valid(o_v[o]), .out_ready(o_rdy[o]), .out_flit(o_fl[o])
      );
    end
  endgenerate

  // an input is taken when dropped or when some output granted it
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      in_rdy[i] = drop_v[i];
      for (int o = 0; o < NPORT; o++)
        in_rdy[i] = in_rdy[i] | gnt[o][i];
    end
  end

  assign yin_ready = in_rdy[IN_Y];
  assign xin_ready = in_rdy[IN_X];
  assign inj_ready = in_rdy[IN_L];

  assign xout_valid = o_v[OUT_X];
  assign xout_flit  = o_fl[OUT_X];
  assign yout_valid = o_v[OUT_Y];
  assign yout_flit  = o_fl[OUT_Y];
  assign ej_valid   = o_v[OUT_E];
  assign ej_flit    = o_fl[OUT_E];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= drop_v[IN_Y] | drop_v[IN_X] | drop_v[IN_L];
  end
  assign dest_err = err_q;

  AST_XOUT_OFF_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    xout_valid |-> (xout_flit[FLIT_W-1 -: CRD_W] != HX)) else $error("X output at home column"); // R1
  AST_YOUT_IN_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    yout_valid |-> ((yout_flit[FLIT_W-1 -: CRD_W] == HX) &&
                    (yout_flit[FLIT_W-CRD_W-1 -: CRD_W] != HY))) else $error("bad Y output"); // R2
  AST_EJECT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> ((ej_flit[FLIT_W-1 -: CRD_W] == HX) &&
                  (ej_flit[FLIT_W-CRD_W-1 -: CRD_W] == HY))) else $error("eject not home"); // R3
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !LOCAL_EN |-> (!inj_ready && !ej_valid)) else $error("disabled tile took local traffic"); // R7
  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_v[IN_L] && !(load[OUT_X] || load[OUT_Y] || load[OUT_E])) |=> dest_err)
    else $error("drop not flagged"); // R6

endmodule

// File: tb/tb_torus_router.sv
module tb_torus_router;

  localparam int W  = 10;
  localparam int H  = 12;
  localparam int FW = 264;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // [instance][port]; instance 0 = dut, 1 = dut_dis
  logic          iv   [2][3];
  logic [FW-1:0] ifl  [2][3];
  logic          ordy [2][3];
  logic          irdy_d [2][3];
  logic          ov_d   [2][3];
  logic [FW-1:0] ofl_d  [2][3];
  logic          err_d  [2];

  int myx [2] = '{9, 3};
  int myy [2] = '{11, 4};
  bit len [2] = '{1'b1, 1'b0};

  // reference model state
  bit          mv  [2][3];
  logic [FW-1:0] mf [2][3];
  bit          merr [2];
  bit          acc [2][3];

  int checks = 0;
  int errors = 0;

  torus_router #(.MY_X(9), .MY_Y(11), .NET_SEL(0), .LOCAL_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .yin_valid(iv[0][0]), .yin_ready(irdy_d[0][0]), .yin_flit(ifl[0][0]),
    .xin_valid(iv[0][1]), .xin_ready(irdy_d[0][1]), .xin_flit(ifl[0][1]),
    .inj_valid(iv[0][2]), .inj_ready(irdy_d[0][2]), .inj_flit(ifl[0][2]),
    .xout_valid(ov_d[0][0]), .xout_ready(ordy[0][0]), .xout_flit(ofl_d[0][0]),
    .yout_valid(ov_d[0][1]), .yout_ready(ordy[0][1]), .yout_flit(ofl_d[0][1]),
    .ej_valid(ov_d[0][2]), .ej_ready(ordy[0][2]), .ej_flit(ofl_d[0][2]),
    .dest_err(err_d[0])
  );

  torus_router #(.MY_X(3), .MY_Y(4), .NET_SEL(1), .LOCAL_EN(1'b0)) dut_dis (
    .clk(clk), .rst_n(rst_n),
    .yin_valid(iv[1][0]), .yin_ready(irdy_d[1][0]), .yin_flit(ifl[1][0]),
    .xin_valid(iv[1][1]), .xin_ready(irdy_d[1][1]), .xin_flit(ifl[1][1]),
    .inj_valid(iv[1][2]), .inj_ready(irdy_d[1][2]), .inj_flit(ifl[1][2]),
    .xout_valid(ov_d[1][0]), .xout_ready(ordy[1][0]), .xout_flit(ofl_d[1][0]),
    .yout_valid(ov_d[1][1]), .yout_ready(ordy[1][1]), .yout_flit(ofl_d[1][1]),
    .ej_valid(ov_d[1][2]), .ej_ready(ordy[1][2]), .ej_flit(ofl_d[1][2]),
    .dest_err(err_d[1])
  );

  function automatic logic [FW-1:0] mk(int dx, int dy, logic [255:0] pl);
    logic [3:0] a, b;
    a = dx[3:0];
    b = dy[3:0];
    return {a, b, pl};
  endfunction

  function automatic logic [255:0] rpl();
    logic [255:0] r;
    for (int j = 0; j < 8; j++) r[j*32 +: 32] = $urandom();
    return r;
  endfunction

  function automatic string otag(int o);
    if (o == 0) return "R1";
    if (o == 1) return "R2";
    return "R3";
  endfunction

  task automatic chk(bit ok, string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle reference model and comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        merr[k] = 1'b0;
        for (int p = 0; p < 3; p++) begin mv[k][p] = 1'b0; acc[k][p] = 1'b0; end
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit taken [3];
        bit ld [3];
        logic [FW-1:0] nf [3];
        bit dropped;
        dropped = 1'b0;
        for (int o = 0; o < 3; o++) begin
          taken[o] = 1'b0; ld[o] = 1'b0; nf[o] = '0;
          checks++;
          if (ov_d[k][o] !== mv[k][o] || (mv[k][o] && ofl_d[k][o] !== mf[k][o])) begin
            errors++;
            $display("FAIL %s inst %0d out %0d got v=%0b %0h exp v=%0b %0h",
                     (ordy[k][o] ? otag(o) : "R5"), k, o, ov_d[k][o], ofl_d[k][o], mv[k][o], mf[k][o]);
          end
        end
        checks++;
        if (err_d[k] !== merr[k]) begin
          errors++;
          $display("FAIL %s inst %0d dest_err got %0b exp %0b", (k == 1) ? "R7" : "R6",
                   k, err_d[k], merr[k]);
        end
        for (int i = 0; i < 3; i++) begin
          bit er;
          er = 1'b0;
          if (iv[k][i] && !(i == 2 && !len[k])) begin
            int dx, dy, o;
            dx = int'(ifl[k][i][263:260]);
            dy = int'(ifl[k][i][259:256]);
            if (dx >= W || dy >= H || (dx == myx[k] && dy == myy[k] && !len[k])) begin
              er = 1'b1;
              dropped = 1'b1;
            end else begin
              o = (dx != myx[k]) ? 0 : ((dy != myy[k]) ? 1 : 2);
              if (!taken[o] && (!mv[k][o] || ordy[k][o])) begin
                er = 1'b1; ld[o] = 1'b1; nf[o] = ifl[k][i];
              end
              taken[o] = 1'b1;
            end
          end
          checks++;
          if (irdy_d[k][i] !== er) begin
            errors++;
            $display("FAIL %s inst %0d in %0d ready got %0b exp %0b",
                     (k == 1 && i == 2) ? "R7" : "R4", k, i, irdy_d[k][i], er);
          end
          acc[k][i] = iv[k][i] && er;
        end
        for (int o = 0; o < 3; o++) begin
          if (mv[k][o] && ordy[k][o]) mv[k][o] = 1'b0;
          if (ld[o]) begin mv[k][o] = 1'b1; mf[k][o] = nf[o]; end
        end
        merr[k] = dropped;
      end
    end
  end

  // advance one cycle and retire accepted inputs
  task automatic tick();
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 3; i++)
        if (acc[k][i]) iv[k][i] = 1'b0;
  endtask

  function automatic logic [FW-1:0] rnd_flit(int k, int i);
    int dx, dy;
    dx = (i == 0) ? myx[k] : int'($urandom % W);
    dy = int'($urandom % H);
    if ($urandom % 100 < 5) begin
      if ($urandom % 2 == 0) dx = 10 + int'($urandom % 6);
      else                   dy = 12 + int'($urandom % 4);
    end
    return mk(dx, dy, rpl());
  endfunction

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] fa, fb, fc, fd, fe, prev;
    int cnt;
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < 3; p++) begin
        iv[k][p] = 1'b0; ifl[k][p] = '0; ordy[k][p] = 1'b1;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      for (int o = 0; o < 3; o++)
        chk(ov_d[k][o] == 1'b0, "R9 reset valid", FW'(ov_d[k][o]), '0);
      chk(err_d[k] == 1'b0, "R9 reset err", FW'(err_d[k]), '0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick();

    // R1: column 9 to column 2 wraps through the edge
    fa = mk(2, 5, rpl());
    iv[0][2] = 1'b1; ifl[0][2] = fa;
    tick();
    @(negedge clk);
    chk(ov_d[0][0] && ofl_d[0][0] == fa, "R1 x forward", ofl_d[0][0], fa);

    // R2
    @(posedge clk); #1;
    fb = mk(9, 3, rpl());
    iv[0][1] = 1'b1; ifl[0][1] = fb;
    tick();
    @(negedge clk);
    chk(ov_d[0][1] && ofl_d[0][1] == fb, "R2 y turn", ofl_d[0][1], fb);

    // R3
    @(posedge clk); #1;
    fc = mk(9, 11, rpl());
    iv[0][2] = 1'b1; ifl[0][2] = fc;
    tick();
    @(negedge clk);
    chk(ov_d[0][2] && ofl_d[0][2] == fc, "R3 eject", ofl_d[0][2], fc);

    // R4: three-way contention for the Y output
    @(posedge clk); #1;
    fa = mk(9, 0, rpl()); fb = mk(9, 1, rpl()); fc = mk(9, 2, rpl());
    iv[0][0] = 1'b1; ifl[0][0] = fa;
    iv[0][1] = 1'b1; ifl[0][1] = fb;
    iv[0][2] = 1'b1; ifl[0][2] = fc;
    @(negedge clk);
    chk(irdy_d[0][0] && !irdy_d[0][1] && !irdy_d[0][2], "R4 y wins",
        FW'({irdy_d[0][0], irdy_d[0][1], irdy_d[0][2]}), FW'(3'b100));
    tick();
    @(negedge clk);
    chk(ofl_d[0][1] == fa, "R4 first", ofl_d[0][1], fa);
    chk(irdy_d[0][1] && !irdy_d[0][2], "R4 x over local",
        FW'({irdy_d[0][1], irdy_d[0][2]}), FW'(2'b10));
    tick();
    @(negedge clk);
    chk(ofl_d[0][1] == fb, "R4 second", ofl_d[0][1], fb);
    tick();
    @(negedge clk);
    chk(ofl_d[0][1] == fc, "R4 third", ofl_d[0][1], fc);

    // R5: stalled Y output
    @(posedge clk); #1;
    ordy[0][1] = 1'b0;
    fd = mk(9, 7, rpl());
    iv[0][0] = 1'b1; ifl[0][0] = fd;
    tick();
    fe = mk(9, 8, rpl());
    iv[0][1] = 1'b1; ifl[0][1] = fe;
    tick();
    tick();
    @(negedge clk);
    chk(ov_d[0][1] && ofl_d[0][1] == fd, "R5 hold", ofl_d[0][1], fd);
    chk(!irdy_d[0][1], "R5 input refused", FW'(irdy_d[0][1]), '0);
    @(posedge clk); #1;
    ordy[0][1] = 1'b1;
    tick();
    @(negedge clk);
    chk(ov_d[0][1] && ofl_d[0][1] == fe, "R5 drain reload", ofl_d[0][1], fe);

    // R6: out-of-range destinations
    @(posedge clk); #1;
    iv[0][2] = 1'b1; ifl[0][2] = mk(12, 0, rpl());
    iv[0][1] = 1'b1; ifl[0][1] = mk(0, 13, rpl());
    @(negedge clk);
    chk(irdy_d[0][2] && irdy_d[0][1], "R6 accept bad",
        FW'({irdy_d[0][1], irdy_d[0][2]}), FW'(2'b11));
    tick();
    @(negedge clk);
    chk(err_d[0] && !ov_d[0][0] && !ov_d[0][1] && !ov_d[0][2], "R6 err no output",
        FW'({err_d[0], ov_d[0][0], ov_d[0][1], ov_d[0][2]}), FW'(4'b1000));
    tick();
    @(negedge clk);
    chk(!err_d[0], "R6 pulse one cycle", FW'(err_d[0]), '0);

    // R8: back-to-back burst on the X output
    cnt = 0;
    prev = '0;
    @(posedge clk); #1;
    for (int j = 0; j < 6; j++) begin
      fa = mk(4, 4, 256'(j + 100));
      iv[0][2] = 1'b1; ifl[0][2] = fa;
      @(negedge clk);
      if (j > 0 && ov_d[0][0] && ofl_d[0][0] == prev) cnt++;
      prev = fa;
      tick();
    end
    @(negedge clk);
    if (ov_d[0][0] && ofl_d[0][0] == prev) cnt++;
    chk(cnt == 6, "R8 burst", FW'(cnt), FW'(6));

    // R7: tile with local traffic disabled (column 3, row 4, reverse net)
    @(posedge clk); #1;
    iv[1][2] = 1'b1; ifl[1][2] = mk(5, 5, rpl());
    fb = mk(5, 4, rpl());
    iv[1][1] = 1'b1; ifl[1][1] = fb;
    @(negedge clk);
    chk(!irdy_d[1][2], "R7 inject refused", FW'(irdy_d[1][2]), '0);
    tick();
    @(negedge clk);
    chk(ov_d[1][0] && ofl_d[1][0] == fb, "R7 transit forwarded", ofl_d[1][0], fb);
    @(posedge clk); #1;
    iv[1][1] = 1'b1; ifl[1][1] = mk(3, 4, rpl());
    @(negedge clk);
    chk(irdy_d[1][1], "R7 home flit taken", FW'(irdy_d[1][1]), FW'(1));
    tick();
    @(negedge clk);
    chk(err_d[1] && !ov_d[1][2], "R7 home flit dropped",
        FW'({err_d[1], ov_d[1][2]}), FW'(2'b10));
    chk(!irdy_d[1][2], "R7 inject still refused", FW'(irdy_d[1][2]), '0);
    @(posedge clk); #1;
    iv[1][2] = 1'b0;

    // mixed traffic, compared every cycle by the model
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #1;
      for (int k = 0; k < 2; k++) begin
        for (int i = 0; i < 3; i++)
          if (!iv[k][i] || acc[k][i]) begin
            iv[k][i] = ($urandom % 100) < 60;
            ifl[k][i] = rnd_flit(k, i);
          end
        for (int o = 0; o < 3; o++) ordy[k][o] = ($urandom % 100) < 75;
      end
    end
    @(posedge clk); #1;
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < 3; p++) begin iv[k][p] = 1'b0; ordy[k][p] = 1'b1; end
    repeat (5) tick();
    @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule